// File: doc/BRIEF.md
# Reloadable Transfer Length Counter

This block keeps the byte-count state of a DMA-capable storage controller. The host loads a staged count one byte at a time into a write-side copy. That copy has three bytes: low, middle and high. The count only reaches the live counter, which the transfer engine consumes, when the host issues a command byte with the DMA flag set. A command without that flag turns DMA mode off and leaves the live counter unchanged.

The transfer engine lowers the live counter by one or two bytes for each beat. The counter stops at zero, and a terminal-count flag goes up the moment it gets there. When a transfer starts, the block works out the effective length: the smaller of the live count and the pending data size, where a live count of zero means 65536.

Until the high count byte has been written once after reset, reading it returns a fixed identification byte. This lets host software tell which controller variant it is talking to.

Top module: `xcnt_top`

## Requirements
- R1: After reset the live counter and the write-side bytes are zero, terminal count and DMA mode are off, the config register reads 7 and xferLen is 0.
- R2: A write to count address 0, 1 or 2 (low, middle, high byte) changes only the write-side copy. A read of addresses 0 and 1 keeps returning the live counter's low and middle bytes.
- R3: A write to the command address 3 with bit 7 set loads the live counter with high<<16 | middle<<8 | low from the write-side copy and sets DMA mode. Both are visible after the next clock edge.
- R4: A command write with bit 7 clear clears DMA mode and leaves the live counter unchanged.
- R5: A write to any count byte clears the terminal-count flag.
- R6: A read of address 2 returns the CHIP_ID parameter (default 8'hA2) until address 2 has been written once after reset. From then on it returns the live counter's high byte.
- R7: While decEn is high, the live counter drops by 2 if decTwo is high and by 1 otherwise, and it never goes below zero. A reload in the same cycle takes priority over the decrement.
- R8: The terminal-count flag is set when a decrement takes the counter from a nonzero value to zero. A decrement at zero leaves the flag as it is.
- R9: One cycle after startXfer, xferLen holds min(L, pendSize), where L is the live count or 65536 when the live count is zero.
- R10: Status address 4 reads bit 0 = terminal count and bit 1 = DMA mode, with the other bits zero.
- R11: Config address 5 is read/write and resets to 7. Addresses 6 and 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| wrEn | input | 1 | Host register write strobe |
| wrAddr | input | 3 | Host write address |
| wrData | input | 8 | Host write data |
| rdAddr | input | 3 | Host read address |
| rdData | output | 8 | Combinational read data |
| decEn | input | 1 | Transfer engine decrement request |
| decTwo | input | 1 | Decrement by two instead of one |
| startXfer | input | 1 | Transfer command start pulse |
| pendSize | input | 24 | Pending data size for the transfer |
| xferLen | output | 24 | Registered effective transfer length |
| tcFlag | output | 1 | Terminal-count flag |
| dmaMode | output | 1 | DMA mode indicator |

## Verification
The hardest case to reach is a reload and a decrement landing in the same clock cycle. The bench gets there by driving decEn on the same falling edge as a flagged command write. It first lowers the counter below the staged value, so the reload's win over the decrement shows up in the read-back. The identification readback is checked both before and after the first high-byte write. A second reset then confirms that the identification value comes back.

// File: rtl/xcnt_pkg.sv
package xcnt_pkg;
  localparam int BYTE_W    = 8;
  localparam int CNT_BYTES = 3;
  localparam int CNT_W     = CNT_BYTES * BYTE_W;
  localparam int ADDR_W    = 3;
  localparam int DMA_BIT   = 7;
  localparam int ZERO_LEN  = 65536;
  localparam int CFG_RST   = 7;

  localparam logic [ADDR_W-1:0] CMD_ADDR  = 3'd3;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 3'd4;
  localparam logic [ADDR_W-1:0] CFG_ADDR  = 3'd5;

  typedef struct packed {
    logic [CNT_BYTES-1:0] wrCnt;
    logic                 reload;
    logic                 decOne;
    logic                 decTwo;
    logic                 start;
  } ctlStrobes_t;
endpackage

// File: rtl/xcnt_ctrl.sv
module xcnt_ctrl
  import xcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              decEn,
  input  logic              decTwo,
  input  logic              startXfer,
  output ctlStrobes_t       strb,
  output logic              dmaMode,
  output logic              hiWritten,
  output logic [BYTE_W-1:0] cfgReg
);
  logic cmdWr;
  assign cmdWr = wrEn && (wrAddr == CMD_ADDR);

  always_comb begin
    strb = '0;
    for (int i = 0; i < CNT_BYTES; i++)
      strb.wrCnt[i] = wrEn && (wrAddr == ADDR_W'(i));
    strb.reload = cmdWr && wrData[DMA_BIT];
    strb.decOne = decEn && !decTwo;
    strb.decTwo = decEn && decTwo;
    strb.start  = startXfer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmaMode   <= 1'b0;
      hiWritten <= 1'b0;
      cfgReg    <= BYTE_W'(CFG_RST);
    end else begin
      if (cmdWr) dmaMode <= wrData[DMA_BIT];
      if (strb.wrCnt[CNT_BYTES-1]) hiWritten <= 1'b1;
      if (wrEn && wrAddr == CFG_ADDR) cfgReg <= wrData;
    end
  end

  // R4
  dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == CMD_ADDR && !wrData[DMA_BIT]) |=> !dmaMode);

  // R6
  hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiWritten |=> hiWritten);
endmodule

// File: rtl/xcnt_datapath.sv
module xcnt_datapath
  import xcnt_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'hA2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  pendSize,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              dmaMode,
  input  logic              hiWritten,
  input  logic [BYTE_W-1:0] cfgReg,
  output logic [BYTE_W-1:0] rdData,
  output logic [CNT_W-1:0]  xferLen,
  output logic              tcFlag
);
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(ZERO_LEN);

  logic [BYTE_W-1:0] shadow [CNT_BYTES];
  logic [CNT_W-1:0]  shadowVal;
  logic [CNT_W-1:0]  live;
  logic [CNT_W-1:0]  step;
  logic [CNT_W-1:0]  effLen;
  logic              decAny;
  logic              wrAny;

  always_comb begin
    for (int i = 0; i < CNT_BYTES; i++)
      shadowVal[i*BYTE_W +: BYTE_W] = shadow[i];
  end

  assign decAny = strb.decOne || strb.decTwo;
  assign wrAny  = |strb.wrCnt;
  assign step   = strb.decTwo ? CNT_W'(2) : CNT_W'(1);
  assign effLen = (live == '0) ? FULL_LEN : live;

  generate
    for (genvar g = 0; g < CNT_BYTES; g++) begin : gShadow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow[g] <= '0;
        else if (strb.wrCnt[g]) shadow[g] <= wrData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live    <= '0;
      tcFlag  <= 1'b0;
      xferLen <= '0;
    end else begin
      if (strb.reload) live <= shadowVal;
      else if (decAny) live <= (live > step) ? live - step : '0;

      if (wrAny) tcFlag <= 1'b0;
      else if (!strb.reload && decAny && live != '0 && live <= step) tcFlag <= 1'b1;

      if (strb.start) xferLen <= (pendSize < effLen) ? pendSize : effLen;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (rdAddr == ADDR_W'(i)) begin
        if (i == CNT_BYTES-1 && !hiWritten) rdData = CHIP_ID;
        else rdData = live[i*BYTE_W +: BYTE_W];
      end
    end
    if (rdAddr == STAT_ADDR) rdData = {6'b0, dmaMode, tcFlag};
    if (rdAddr == CFG_ADDR)  rdData = cfgReg;
  end

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.reload |=> live == $past(shadowVal));

  // R5
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrAny |=> !tcFlag);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decAny && !strb.reload && live == '0) |=> live == '0);

  // R8
  tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decAny && !strb.reload && !wrAny && live != '0 && live <= step) |=> tcFlag);
endmodule

// File: rtl/xcnt_top.sv
module xcnt_top
  import xcnt_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'hA2
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [2:0]  rdAddr,
  output logic [7:0]  rdData,
  input  logic        decEn,
  input  logic        decTwo,
  input  logic        startXfer,
  input  logic [23:0] pendSize,
  output logic [23:0] xferLen,
  output logic        tcFlag,
  output logic        dmaMode
);
  ctlStrobes_t       strb;
  logic              hiWritten;
  logic [BYTE_W-1:0] cfgReg;

  xcnt_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .decEn(decEn), .decTwo(decTwo), .startXfer(startXfer), .strb(strb),
    .dmaMode(dmaMode), .hiWritten(hiWritten), .cfgReg(cfgReg)
  );

  xcnt_datapath #(.CHIP_ID(CHIP_ID)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .pendSize(pendSize), .rdAddr(rdAddr), .dmaMode(dmaMode),
    .hiWritten(hiWritten), .cfgReg(cfgReg), .rdData(rdData),
    .xferLen(xferLen), .tcFlag(tcFlag)
  );
endmodule

// File: tb/tb_xcnt_top.sv
module tb_xcnt_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        decEn = 1'b0;
  logic        decTwo = 1'b0;
  logic        startXfer = 1'b0;
  logic [23:0] pendSize = '0;
  logic [23:0] xferLen;
  logic        tcFlag;
  logic        dmaMode;

  int total = 0;
  int bad = 0;

  xcnt_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic dec(input logic two);
    @(negedge clk);
    decEn = 1'b1; decTwo = two;
    @(negedge clk);
    decEn = 1'b0; decTwo = 1'b0;
  endtask

  task automatic startT(input logic [23:0] p);
    @(negedge clk);
    startXfer = 1'b1; pendSize = p;
    @(negedge clk);
    startXfer = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic testReset();
    logic [7:0] v;
    rd(3'd0, v); check("R1 live lo", {16'b0, v}, 24'h0);
    rd(3'd1, v); check("R1 live mid", {16'b0, v}, 24'h0);
    rd(3'd4, v); check("R1 status", {16'b0, v}, 24'h0);
    rd(3'd5, v); check("R1 cfg", {16'b0, v}, 24'h7);
    check("R1 xferLen", xferLen, 24'h0);
    rd(3'd2, v); check("R6 chip id", {16'b0, v}, 24'hA2);
  endtask

  task automatic testShadow();
    logic [7:0] v;
    wr(3'd0, 8'h05);
    wr(3'd1, 8'h01);
    rd(3'd0, v); check("R2 lo unchanged", {16'b0, v}, 24'h0);
    rd(3'd1, v); check("R2 mid unchanged", {16'b0, v}, 24'h0);
    rd(3'd2, v); check("R6 id before hi write", {16'b0, v}, 24'hA2);
    wr(3'd2, 8'h00);
    rd(3'd2, v); check("R6 live hi after write", {16'b0, v}, 24'h0);
  endtask

  task automatic testReload();
    logic [7:0] v;
    wr(3'd3, 8'h90);
    rd(3'd0, v); check("R3 reload lo", {16'b0, v}, 24'h05);
    rd(3'd1, v); check("R3 reload mid", {16'b0, v}, 24'h01);
    rd(3'd4, v); check("R10 status dma", {16'b0, v}, 24'h2);
    wr(3'd3, 8'h10);
    rd(3'd4, v); check("R4 dma cleared", {16'b0, v}, 24'h0);
    rd(3'd0, v); check("R4 live kept", {16'b0, v}, 24'h05);
  endtask

  task automatic testDec();
    logic [7:0] v;
    dec(1'b1); dec(1'b1);
    rd(3'd0, v); check("R7 dec2 lo", {16'b0, v}, 24'h01);
    dec(1'b0);
    rd(3'd0, v); check("R7 dec1 lo", {16'b0, v}, 24'h00);
    rd(3'd1, v); check("R7 dec1 mid", {16'b0, v}, 24'h01);
    check("R8 tc not yet", {23'b0, tcFlag}, 24'h0);
  endtask

  task automatic testTerminal();
    logic [7:0] v;
    wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd3, 8'h80);
    dec(1'b1);
    rd(3'd0, v); check("R7 saturate at zero", {16'b0, v}, 24'h0);
    check("R8 tc set", {23'b0, tcFlag}, 24'h1);
    dec(1'b0);
    rd(3'd0, v); check("R7 stays zero", {16'b0, v}, 24'h0);
    rd(3'd4, v); check("R10 status tc", {16'b0, v}, 24'h3);
    wr(3'd0, 8'h00);
    check("R5 tc cleared", {23'b0, tcFlag}, 24'h0);
  endtask

  task automatic testLength();
    logic [7:0] v;
    startT(24'h020000);
    check("R9 zero means 65536", xferLen, 24'h010000);
    startT(24'h000030);
    check("R9 pend smaller", xferLen, 24'h000030);
    wr(3'd0, 8'h56); wr(3'd1, 8'h34); wr(3'd2, 8'h12);
    wr(3'd3, 8'h80);
    startT(24'hFFFFFF);
    check("R9 live smaller", xferLen, 24'h123456);
    rd(3'd2, v); check("R6 live hi", {16'b0, v}, 24'h12);
  endtask

  task automatic testCollide();
    logic [7:0] v;
    dec(1'b1);
    rd(3'd0, v); check("R7 dec before collide", {16'b0, v}, 24'h54);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd3; wrData = 8'h80; decEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; decEn = 1'b0;
    rd(3'd0, v); check("R7 reload wins", {16'b0, v}, 24'h56);
  endtask

  task automatic testCfg();
    logic [7:0] v;
    wr(3'd5, 8'h3C);
    rd(3'd5, v); check("R11 cfg write", {16'b0, v}, 24'h3C);
    wr(3'd7, 8'hFF);
    rd(3'd7, v); check("R11 unused reads zero", {16'b0, v}, 24'h0);
    doReset();
    rd(3'd5, v); check("R11 cfg reset", {16'b0, v}, 24'h7);
    rd(3'd2, v); check("R6 id back after reset", {16'b0, v}, 24'hA2);
    rd(3'd0, v); check("R1 live after reset", {16'b0, v}, 24'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testShadow();
    testReload();
    testDec();
    testTerminal();
    testLength();
    testCollide();
    testCfg();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule